// File: doc/BRIEF.md
# Double-Rate Write Pair Assembler

This block sits on the device side of a double-data-rate write path, after the strobe-edge capture flops. The capture logic hands it one n-bit word per transfer slot in the core clock domain, together with one mask bit for each byte lane of that word. The assembler groups consecutive words of a write burst into pairs and issues one 2n-bit core write per pair. The core write carries a byte-enable vector, so the array can skip any lane the controller masked.

A burst opens when a word arrives with the burst-start flag set. The burst-length code sampled with that word sets how many words belong to the burst: 2, 4 or 8. A pair always occupies both transfer slots, even when the controller masks one word or both. The write for a pair is issued only after its second word is in, and a further burst may begin on the very next word.

Top module: `pf_write_assembler`

## Requirements
- R1: After reset, core_wr and core_last are 0, and core_data and core_be are all zeros.
- R2: core_wr is high for exactly one cycle per completed pair, in the cycle after the second word of that pair was accepted. It is never high in any other cycle.
- R3: The first word of a pair appears in core_data bits [WORD_W-1:0] and the second word in bits [2*WORD_W-1:WORD_W].
- R4: Lane i of a word covers data bits [8i+7:8i]. A word_mask bit of 1 clears that lane's enable. core_be bits [LANES-1:0] come from the first word and bits [2*LANES-1:LANES] from the second.
- R5: A pair whose words are both fully masked still produces a core_wr pulse, with core_be equal to zero.
- R6: burst_len is sampled only with the opening word. Code 0 selects 2 words, code 1 selects 4, and codes 2 and 3 select 8. core_last is high together with core_wr for the final pair of a burst and is low at all other times.
- R7: A burst opens only when burst_start and word_valid are high together. burst_start without word_valid has no effect, and words that arrive outside a burst without burst_start are ignored.
- R8: Cycles with word_valid low inside a burst consume no transfer slot, and pairing resumes with the next valid word.
- R9: A new burst may open on the word right after the final word of the previous burst, with no idle cycle between them.
- R10: burst_start with word_valid during an active burst abandons that burst. A pending unpaired first word is dropped without any write, and the new word becomes the first word of the new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_valid | input | 1 | A captured word is present this cycle |
| burst_start | input | 1 | The present word opens a new write burst |
| burst_len | input | 2 | Burst-length code, sampled with the opening word |
| word_data | input | WORD_W | Captured write word |
| word_mask | input | WORD_W/8 | Per-lane mask of the word, 1 = do not write |
| core_wr | output | 1 | One-cycle strobe for a 2n-bit core write |
| core_data | output | 2*WORD_W | Paired write data, first word in the low half |
| core_be | output | 2*WORD_W/8 | Byte enables for the paired write |
| core_last | output | 1 | The strobed pair closes its burst |

## Verification
Two functions can fall in the same cycle, and both cases are checked. In the first, the final pair of one burst is being strobed out while the opening word of the next burst is accepted: a burst is started on the word right after a closing word, and the bench checks that the closing write carries core_last and the right enables while the next pair still forms correctly. In the second, a restart lands on a pending first word: burst_start is raised while half a pair is held, and the bench checks that no write appears and that the next write pairs the new opening word rather than the dropped one. Random streams then exercise both cases against a reference model and a shadow memory.

// File: rtl/wpa_pkg.sv
package wpa_pkg;

    // burst-length codes as sampled with the opening word
    typedef enum logic [1:0] {
        BL_TWO    = 2'd0,
        BL_FOUR   = 2'd1,
        BL_EIGHT  = 2'd2,
        BL_EIGHTX = 2'd3
    } blen_code_e;

    localparam int MAX_BURST = 8;
    localparam int CNT_W     = $clog2(MAX_BURST) + 1;

    function automatic logic [CNT_W-1:0] words_for(input blen_code_e code);
        case (code)
            BL_TWO:  words_for = CNT_W'(2);
            BL_FOUR: words_for = CNT_W'(4);
            default: words_for = CNT_W'(MAX_BURST);
        endcase
    endfunction

endpackage

// File: rtl/wpa_len_decode.sv
module wpa_len_decode
    import wpa_pkg::*;
(
    input  logic [1:0]       len_code,
    output logic [CNT_W-1:0] burst_words
);
    always_comb begin
        burst_words = words_for(blen_code_e'(len_code));
    end
endmodule

// File: rtl/wpa_byte_enable.sv
module wpa_byte_enable #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] mask,
    output logic [LANES-1:0] enable
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign enable[g] = ~mask[g];
    end
endmodule

// File: rtl/pf_write_assembler.sv
module pf_write_assembler
    import wpa_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LANE_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          word_valid,
    input  logic                          burst_start,
    input  logic [1:0]                    burst_len,
    input  logic [WORD_W-1:0]             word_data,
    input  logic [WORD_W/LANE_W-1:0]      word_mask,
    output logic                          core_wr,
    output logic [2*WORD_W-1:0]           core_data,
    output logic [2*(WORD_W/LANE_W)-1:0]  core_be,
    output logic                          core_last
);
    localparam int LANES = WORD_W / LANE_W;
    localparam int PAIR_W = 2 * WORD_W;
    localparam int PAIR_L = 2 * LANES;

    typedef struct packed {
        logic                active;
        logic                pend;
        logic [CNT_W-1:0]    left;
        logic [WORD_W-1:0]   lo_data;
        logic [LANES-1:0]    lo_be;
        logic                wr;
        logic                last;
        logic [PAIR_W-1:0]   data;
        logic [PAIR_L-1:0]   be;
    } asm_state_t;

    asm_state_t st_d, st_q;
    logic [CNT_W-1:0] burst_words;
    logic [LANES-1:0] be_now;

    wpa_len_decode u_len (
        .len_code    (burst_len),
        .burst_words (burst_words)
    );

    wpa_byte_enable #(.LANES(LANES)) u_be (
        .mask   (word_mask),
        .enable (be_now)
    );

    always_comb begin
        st_d      = st_q;
        st_d.wr   = 1'b0;
        st_d.last = 1'b0;
        if (word_valid) begin
            if (burst_start) begin
                // opening word, any pending half is abandoned
                st_d.active  = 1'b1;
                st_d.pend    = 1'b1;
                st_d.lo_data = word_data;
                st_d.lo_be   = be_now;
                st_d.left    = burst_words - CNT_W'(1);
            end else if (st_q.active) begin
                st_d.left = st_q.left - CNT_W'(1);
                if (st_q.pend) begin
                    st_d.pend = 1'b0;
                    st_d.wr   = 1'b1;
                    st_d.data = {word_data, st_q.lo_data};
                    st_d.be   = {be_now, st_q.lo_be};
                    if (st_q.left == CNT_W'(1)) begin
                        st_d.last   = 1'b1;
                        st_d.active = 1'b0;
                    end
                end else begin
                    st_d.pend    = 1'b1;
                    st_d.lo_data = word_data;
                    st_d.lo_be   = be_now;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign core_wr   = st_q.wr;
    assign core_last = st_q.last;
    assign core_data = st_q.data;
    assign core_be   = st_q.be;

endmodule

// File: rtl/wpa_checker.sv
module wpa_checker #(
    parameter int WORD_W = 32,
    parameter int LANE_W = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          word_valid,
    input logic                          burst_start,
    input logic [WORD_W-1:0]             word_data,
    input logic [WORD_W/LANE_W-1:0]      word_mask,
    input logic                          core_wr,
    input logic [2*WORD_W-1:0]           core_data,
    input logic [2*(WORD_W/LANE_W)-1:0]  core_be,
    input logic                          core_last
);
    localparam int LANES = WORD_W / LANE_W;

    a_r2_strobe_after_word: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |=> !core_wr);

    a_r10_open_never_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && burst_start) |=> !core_wr);

    a_r3_upper_is_second: assert property (@(posedge clk) disable iff (!rst_n)
        core_wr |-> core_data[2*WORD_W-1:WORD_W] == $past(word_data));

    a_r4_upper_enables: assert property (@(posedge clk) disable iff (!rst_n)
        core_wr |-> core_be[2*LANES-1:LANES] == ~$past(word_mask));

    a_r6_last_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        core_last |-> core_wr);

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        core_wr |=> !core_wr);
endmodule

bind pf_write_assembler wpa_checker #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_valid  (word_valid),
    .burst_start (burst_start),
    .word_data   (word_data),
    .word_mask   (word_mask),
    .core_wr     (core_wr),
    .core_data   (core_data),
    .core_be     (core_be),
    .core_last   (core_last)
);

// File: tb/pf_write_assembler_tb.sv
module pf_write_assembler_tb;
    localparam int W = 32;
    localparam int L = 4;
    localparam int NV = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic word_valid = 1'b0, burst_start = 1'b0;
    logic [1:0] burst_len = '0;
    logic [W-1:0] word_data = '0;
    logic [L-1:0] word_mask = '0;
    logic core_wr, core_last;
    logic [2*W-1:0] core_data;
    logic [2*L-1:0] core_be;

    int checks = 0, fails = 0;

    // {valid, start, len[1:0], mask[3:0], data[31:0]}
    localparam logic [39:0] VEC [NV] = '{
        40'hC0_11111111, 40'h80_22222222,                   // len 2, plain pair
        40'hDF_33333333, 40'h8F_44444444,                   // R5 all masked pair
        40'h00_00000000,                                    // R8 pause
        40'h85_55555555, 40'h8A_66666666,                   // mixed masks, last
        40'hE0_77777777, 40'h80_88888888,                   // R9 back-to-back open
        40'h83_99999999,                                    // pending half
        40'hC0_AAAAAAAA, 40'h8C_BBBBBBBB,                   // R10 restart mid-pair
        40'h80_CCCCCCCC, 40'h40_00000000, 40'h80_DDDDDDDD   // R7 ignored
    };

    pf_write_assembler #(.WORD_W(W), .LANE_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .burst_start(burst_start),
        .burst_len(burst_len), .word_data(word_data), .word_mask(word_mask),
        .core_wr(core_wr), .core_data(core_data), .core_be(core_be), .core_last(core_last)
    );

    always #10 clk = ~clk;

    // reference model state
    logic m_active = 0, m_pend = 0;
    int m_left = 0;
    logic [W-1:0] m_lo = '0;
    logic [L-1:0] m_lom = '0;
    logic [2*W-1:0] ref_mem [16];
    logic [2*W-1:0] dut_mem [16];
    int ref_ptr = 0, dut_ptr = 0;

    function automatic int blen(input logic [1:0] c);
        return (c == 2'd0) ? 2 : (c == 2'd1) ? 4 : 8;
    endfunction

    function automatic logic [2*W-1:0] merge(input logic [2*W-1:0] old,
                                              input logic [2*W-1:0] d,
                                              input logic [2*L-1:0] be);
        logic [2*W-1:0] r = old;
        for (int i = 0; i < 2*L; i++) if (be[i]) r[8*i +: 8] = d[8*i +: 8];
        return r;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [2*W-1:0] act,
                       input logic [2*W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic s, input logic [1:0] l,
                        input logic [L-1:0] m, input logic [W-1:0] d);
        logic e_wr = 0, e_last = 0;
        logic [2*W-1:0] e_data = '0;
        logic [2*L-1:0] e_be = '0;
        word_valid = v; burst_start = s; burst_len = l; word_mask = m; word_data = d;
        if (v) begin
            if (s) begin
                m_active = 1; m_pend = 1; m_lo = d; m_lom = ~m; m_left = blen(l) - 1;
            end else if (m_active) begin
                m_left--;
                if (m_pend) begin
                    e_wr = 1; e_data = {d, m_lo}; e_be = {~m, m_lom}; m_pend = 0;
                    if (m_left == 0) begin e_last = 1; m_active = 0; end
                end else begin
                    m_pend = 1; m_lo = d; m_lom = ~m;
                end
            end
        end
        @(negedge clk);
        chk(core_wr == e_wr, "R2 R7 R8 R10 strobe", 64'(core_wr), 64'(e_wr));
        chk(core_last == e_last, "R6 R9 last", 64'(core_last), 64'(e_last));
        if (e_wr) begin
            chk(core_data == e_data, "R3 data", core_data, e_data);
            chk(core_be == e_be, "R4 R5 enables", 64'(core_be), 64'(e_be));
            ref_mem[ref_ptr] = merge(ref_mem[ref_ptr], e_data, e_be);
            ref_ptr = (ref_ptr + 1) % 16;
        end
        if (core_wr) begin
            dut_mem[dut_ptr] = merge(dut_mem[dut_ptr], core_data, core_be);
            dut_ptr = (dut_ptr + 1) % 16;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin ref_mem[i] = '0; dut_mem[i] = '0; end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(core_wr == 0 && core_last == 0, "R1 strobes", 64'({core_wr, core_last}), 64'd0);
        chk(core_data == '0 && core_be == '0, "R1 data", core_data ^ 64'(core_be), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++)
            step(VEC[i][39], VEC[i][38], VEC[i][37:36], VEC[i][35:32], VEC[i][31:0]);
        // R6 code 3 is a burst of eight, with a closing pair on the 8th word
        step(1, 1, 2'd3, 4'h0, 32'h0BAD0001);
        for (int i = 0; i < 7; i++) step(1, 0, 2'd0, 4'(i), 32'h0BAD0002 + 32'(i));
        // R9 close and reopen, then R10 restart right after a closed pair
        step(1, 1, 2'd0, 4'h1, 32'hC0DE0001);
        step(1, 0, 2'd0, 4'h2, 32'hC0DE0002);
        step(1, 1, 2'd1, 4'h0, 32'hC0DE0003);
        step(1, 0, 2'd0, 4'h0, 32'hC0DE0004);
        step(1, 1, 2'd0, 4'hF, 32'hC0DE0005);
        step(1, 0, 2'd0, 4'hF, 32'hC0DE0006);
        // random streams
        for (int i = 0; i < 400; i++) begin
            logic v = ($urandom % 5) != 0;
            logic s = m_active ? (($urandom % 16) == 0) : (($urandom % 3) == 0);
            step(v, s, 2'($urandom), 4'($urandom), $urandom);
        end
        step(0, 0, 2'd0, 4'h0, 32'h0);
        for (int i = 0; i < 16; i++)
            chk(dut_mem[i] == ref_mem[i], "R4 memory image", dut_mem[i], ref_mem[i]);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule